// File: doc/BRIEF.md
# System-Call Entry and Return Unit

This unit performs the register side effects of a fast privilege-raising call and its matching return on a core with four privilege rings. When the call strobe is seen, it captures the caller's instruction pointer and flags word into two link registers, clears the flag bits selected by a configured mask, and redirects execution to a configured entry address under kernel code and stack selectors. All of these effects land on one clock edge. The caller supplies no target: the destination always comes from configuration.

The return strobe undoes the transfer. It restores the pointer and flags from the link registers and loads the configured user selectors. A return is only legal from the most privileged ring. From any other ring it changes no state and pulses a protection-fault output instead. The current ring is always read from the two low bits of the incoming code selector (0 is most trusted, 3 least). Selectors are 16 bits wide: index in [15:3], table flag in [2] and ring in [1:0].

The two strobes and the configuration write are single-cycle commands. Each is accepted in the cycle it is high, and there is no back-pressure. The `redirect` pulse tells the core that the `nxt_*` outputs hold a new architectural state.

Top module: `sysentry_unit`

## Requirements
- R1: While `rst_n` is low, every output register reads zero, including `redirect` and `gp_fault`.
- R2: A cycle with `syscall_req` high copies `cur_ip` into `link_ip` and `cur_flags` into `link_flags`, visible after the next rising edge.
- R3: On that same edge, `nxt_ip` becomes the configured entry target and `nxt_flags` becomes `cur_flags` AND NOT the configured flag mask.
- R4: On entry, `nxt_cs` and `nxt_ss` take the configured kernel code and stack selectors, with bits [1:0] forced to 00.
- R5: An entry or a legal return raises `redirect` for exactly the one cycle after the strobe, and every output of that transfer is already updated in that cycle.
- R6: `sysret_req` with `cur_cs[1:0]` = 0 (and no `syscall_req`) loads `nxt_ip` from `link_ip` and `nxt_flags` from `link_flags`. It loads `nxt_cs` and `nxt_ss` from the configured user selectors with bits [1:0] forced to 11. The link registers keep their values.
- R7: `sysret_req` with `cur_cs[1:0]` nonzero (and no `syscall_req`) pulses `gp_fault` for one cycle and leaves every other output unchanged.
- R8: When both strobes are high together, the entry is performed and no fault is raised, whatever the current ring.
- R9: A configuration write stores `cfg_wdata` when `cfg_we` is high, using selector codes 0 = entry target, 1 = flag mask (low bits), 2 = kernel code selector, 3 = kernel stack selector, 4 = user code selector, 5 = user stack selector (low 16 bits). Codes 6 and 7 store nothing. A strobe in the same cycle as a write uses the value held before the write.
- R10: In a cycle with neither strobe, all state outputs hold and `redirect` and `gp_fault` are low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| syscall_req | input | 1 | Privilege-raising call strobe |
| sysret_req | input | 1 | Return strobe |
| cur_ip | input | IP_W | Instruction pointer of the calling instruction |
| cur_flags | input | FL_W | Current flags word |
| cur_cs | input | 16 | Current code selector; bits [1:0] give the ring |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | IP_W | Configuration write data |
| nxt_ip | output | IP_W | Instruction pointer after the transfer |
| nxt_flags | output | FL_W | Flags word after the transfer |
| nxt_cs | output | 16 | Code selector after the transfer |
| nxt_ss | output | 16 | Stack selector after the transfer |
| link_ip | output | IP_W | Saved return pointer |
| link_flags | output | FL_W | Saved flags word |
| redirect | output | 1 | One-cycle pulse: `nxt_*` carry a new state |
| gp_fault | output | 1 | One-cycle pulse: illegal return rejected |

## Verification
Entry and return can both be requested in the same cycle, and so can a return from a user ring that would otherwise fault. The bench provokes both collisions with directed cycles that raise the two strobes together while `cur_cs` carries ring 3. It also drives thousands of random cycles in which the strobes, the ring bits and configuration writes overlap freely. A behavioural model settles each cycle with entry first, and its outputs are compared with the design's on every clock. A collision is judged correct only if the entry effects appear, `gp_fault` stays low, and the link registers hold the caller's pointer rather than an earlier value.

// File: rtl/sysent_pkg.sv
package sysent_pkg;
  localparam int SEL_W = 16;
  localparam int RPL_W = 2;
  localparam int CFG_SEL_W = 3;
  localparam int NUM_SEL_REGS = 4;

  typedef enum logic [1:0] {
    XF_IDLE   = 2'd0,
    XF_ENTER  = 2'd1,
    XF_RETURN = 2'd2,
    XF_FAULT  = 2'd3
  } xfer_op_e;

  localparam logic [CFG_SEL_W-1:0] CFG_TARGET = 3'd0;
  localparam logic [CFG_SEL_W-1:0] CFG_MASK   = 3'd1;
  localparam logic [CFG_SEL_W-1:0] CFG_SEL0   = 3'd2;

  localparam int SEL_KCODE  = 0;
  localparam int SEL_KSTACK = 1;
  localparam int SEL_UCODE  = 2;
  localparam int SEL_USTACK = 3;

  localparam logic [RPL_W-1:0] RING_KERNEL = 2'b00;
  localparam logic [RPL_W-1:0] RING_USER   = 2'b11;
endpackage

// File: rtl/sysent_cfg_file.sv
module sysent_cfg_file
  import sysent_pkg::*;
#(
  parameter int IP_W = 64,
  parameter int FL_W = 32
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cfg_we,
  input  logic [CFG_SEL_W-1:0]                cfg_sel,
  input  logic [IP_W-1:0]                     cfg_wdata,
  output logic [IP_W-1:0]                     entry_target,
  output logic [FL_W-1:0]                     flag_mask,
  output logic [NUM_SEL_REGS-1:0][SEL_W-1:0]  sel_bank
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_target <= '0;
      flag_mask    <= '0;
    end else if (cfg_we) begin
      if (cfg_sel == CFG_TARGET) entry_target <= cfg_wdata;
      if (cfg_sel == CFG_MASK)   flag_mask    <= cfg_wdata[FL_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_SEL_REGS; g++) begin : g_sel
    localparam logic [CFG_SEL_W-1:0] CODE = CFG_SEL0 + CFG_SEL_W'(g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        sel_bank[g] <= '0;
      else if (cfg_we && cfg_sel == CODE) sel_bank[g] <= cfg_wdata[SEL_W-1:0];
    end
  end
endmodule

// File: rtl/sysent_op_decode.sv
module sysent_op_decode
  import sysent_pkg::*;
(
  input  logic             syscall_req,
  input  logic             sysret_req,
  input  logic [RPL_W-1:0] cur_ring,
  output xfer_op_e         op
);
  always_comb begin
    if (syscall_req)                   op = XF_ENTER;
    else if (!sysret_req)              op = XF_IDLE;
    else if (cur_ring == RING_KERNEL)  op = XF_RETURN;
    else                               op = XF_FAULT;
  end
endmodule

// File: rtl/sysent_next_state.sv
module sysent_next_state
  import sysent_pkg::*;
#(
  parameter int IP_W = 64,
  parameter int FL_W = 32
) (
  input  xfer_op_e                            op,
  input  logic [IP_W-1:0]                     cur_ip,
  input  logic [FL_W-1:0]                     cur_flags,
  input  logic [IP_W-1:0]                     link_ip,
  input  logic [FL_W-1:0]                     link_flags,
  input  logic [IP_W-1:0]                     entry_target,
  input  logic [FL_W-1:0]                     flag_mask,
  input  logic [NUM_SEL_REGS-1:0][SEL_W-1:0]  sel_bank,
  output logic                                ld_arch,
  output logic                                ld_link,
  output logic [IP_W-1:0]                     d_ip,
  output logic [FL_W-1:0]                     d_flags,
  output logic [SEL_W-1:0]                    d_cs,
  output logic [SEL_W-1:0]                    d_ss
);
  localparam int HI_W = SEL_W - RPL_W;

  always_comb begin
    ld_link = (op == XF_ENTER);
    ld_arch = (op == XF_ENTER) || (op == XF_RETURN);
    if (op == XF_ENTER) begin
      d_ip    = entry_target;
      d_flags = cur_flags & ~flag_mask;
      d_cs    = {sel_bank[SEL_KCODE][SEL_W-1:RPL_W],  RING_KERNEL};
      d_ss    = {sel_bank[SEL_KSTACK][SEL_W-1:RPL_W], RING_KERNEL};
    end else begin
      d_ip    = link_ip;
      d_flags = link_flags;
      d_cs    = {sel_bank[SEL_UCODE][SEL_W-1:RPL_W],  RING_USER};
      d_ss    = {sel_bank[SEL_USTACK][SEL_W-1:RPL_W], RING_USER};
    end
  end

  logic [HI_W-1:0] unused_hi;
  assign unused_hi = '0;
endmodule

// File: rtl/sysentry_unit.sv
module sysentry_unit
  import sysent_pkg::*;
#(
  parameter int IP_W = 64,
  parameter int FL_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 syscall_req,
  input  logic                 sysret_req,
  input  logic [IP_W-1:0]      cur_ip,
  input  logic [FL_W-1:0]      cur_flags,
  input  logic [SEL_W-1:0]     cur_cs,
  input  logic                 cfg_we,
  input  logic [CFG_SEL_W-1:0] cfg_sel,
  input  logic [IP_W-1:0]      cfg_wdata,
  output logic [IP_W-1:0]      nxt_ip,
  output logic [FL_W-1:0]      nxt_flags,
  output logic [SEL_W-1:0]     nxt_cs,
  output logic [SEL_W-1:0]     nxt_ss,
  output logic [IP_W-1:0]      link_ip,
  output logic [FL_W-1:0]      link_flags,
  output logic                 redirect,
  output logic                 gp_fault
);
  logic [IP_W-1:0]                    entry_target;
  logic [FL_W-1:0]                    flag_mask;
  logic [NUM_SEL_REGS-1:0][SEL_W-1:0] sel_bank;
  xfer_op_e                           op;
  logic                               ld_arch, ld_link;
  logic [IP_W-1:0]                    d_ip;
  logic [FL_W-1:0]                    d_flags;
  logic [SEL_W-1:0]                   d_cs, d_ss;
  logic [RPL_W-1:0]                   cur_ring;

  assign cur_ring = cur_cs[RPL_W-1:0];

  sysent_cfg_file #(.IP_W(IP_W), .FL_W(FL_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .entry_target(entry_target),
    .flag_mask(flag_mask), .sel_bank(sel_bank)
  );

  sysent_op_decode u_dec (
    .syscall_req(syscall_req), .sysret_req(sysret_req),
    .cur_ring(cur_ring), .op(op)
  );

  sysent_next_state #(.IP_W(IP_W), .FL_W(FL_W)) u_nxt (
    .op(op), .cur_ip(cur_ip), .cur_flags(cur_flags),
    .link_ip(link_ip), .link_flags(link_flags),
    .entry_target(entry_target), .flag_mask(flag_mask), .sel_bank(sel_bank),
    .ld_arch(ld_arch), .ld_link(ld_link),
    .d_ip(d_ip), .d_flags(d_flags), .d_cs(d_cs), .d_ss(d_ss)
  );

  // All transfer effects commit on one edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nxt_ip     <= '0;
      nxt_flags  <= '0;
      nxt_cs     <= '0;
      nxt_ss     <= '0;
      link_ip    <= '0;
      link_flags <= '0;
      redirect   <= 1'b0;
      gp_fault   <= 1'b0;
    end else begin
      redirect <= ld_arch;
      gp_fault <= (op == XF_FAULT);
      if (ld_arch) begin
        nxt_ip    <= d_ip;
        nxt_flags <= d_flags;
        nxt_cs    <= d_cs;
        nxt_ss    <= d_ss;
      end
      if (ld_link) begin
        link_ip    <= cur_ip;
        link_flags <= cur_flags;
      end
    end
  end

  a_r2_link_capture: assert property (@(posedge clk) disable iff (!rst_n)
    syscall_req |=> (link_ip == $past(cur_ip)) && (link_flags == $past(cur_flags)));

  a_r4_kernel_ring: assert property (@(posedge clk) disable iff (!rst_n)
    syscall_req |=> (nxt_cs[1:0] == 2'b00) && (nxt_ss[1:0] == 2'b00));

  a_r5_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
    syscall_req |=> redirect && (nxt_ip == $past(entry_target)));

  a_r6_user_ring: assert property (@(posedge clk) disable iff (!rst_n)
    (sysret_req && !syscall_req && cur_cs[1:0] == 2'b00) |=>
      redirect && (nxt_cs[1:0] == 2'b11) && (nxt_ss[1:0] == 2'b11) && $stable(link_ip));

  a_r7_fault_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sysret_req && !syscall_req && cur_cs[1:0] != 2'b00) |=>
      gp_fault && !redirect && $stable(nxt_ip) && $stable(nxt_cs) && $stable(link_ip));

  a_r8_entry_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (syscall_req && sysret_req) |=> redirect && !gp_fault);

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!syscall_req && !sysret_req) |=>
      !redirect && !gp_fault && $stable(nxt_ip) && $stable(nxt_flags) && $stable(link_flags));

  a_r5_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(redirect && gp_fault));
endmodule

// File: tb/test_sysentry_unit.sv
`timescale 1ns/1ps
module test_sysentry_unit;
  localparam int IP_W = 64;
  localparam int FL_W = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            syscall_req = 1'b0, sysret_req = 1'b0;
  logic [IP_W-1:0] cur_ip = '0;
  logic [FL_W-1:0] cur_flags = '0;
  logic [15:0]     cur_cs = '0;
  logic            cfg_we = 1'b0;
  logic [2:0]      cfg_sel = '0;
  logic [IP_W-1:0] cfg_wdata = '0;
  logic [IP_W-1:0] nxt_ip, link_ip;
  logic [FL_W-1:0] nxt_flags, link_flags;
  logic [15:0]     nxt_cs, nxt_ss;
  logic            redirect, gp_fault;

  always #2.5 clk = ~clk;

  sysentry_unit #(.IP_W(IP_W), .FL_W(FL_W)) i_sysentry_unit (
    .clk(clk), .rst_n(rst_n), .syscall_req(syscall_req), .sysret_req(sysret_req),
    .cur_ip(cur_ip), .cur_flags(cur_flags), .cur_cs(cur_cs),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .nxt_ip(nxt_ip), .nxt_flags(nxt_flags), .nxt_cs(nxt_cs), .nxt_ss(nxt_ss),
    .link_ip(link_ip), .link_flags(link_flags),
    .redirect(redirect), .gp_fault(gp_fault)
  );

  // Behavioural reference model
  logic [IP_W-1:0] m_target, m_ip, m_link_ip;
  logic [FL_W-1:0] m_mask, m_flags, m_link_flags;
  logic [15:0]     m_kcs, m_kss, m_ucs, m_uss, m_cs, m_ss;
  logic            m_redir, m_fault;
  string           tag = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_target = '0; m_mask = '0; m_kcs = '0; m_kss = '0; m_ucs = '0; m_uss = '0;
      m_ip = '0; m_flags = '0; m_cs = '0; m_ss = '0;
      m_link_ip = '0; m_link_flags = '0; m_redir = 0; m_fault = 0;
      tag = "R1";
    end else begin
      m_redir = 0; m_fault = 0;
      if (syscall_req) begin
        tag = sysret_req ? "R8" : (cfg_we ? "R9" : "R3");
        m_link_ip = cur_ip;
        m_link_flags = cur_flags;
        m_ip = m_target;
        m_flags = cur_flags & ~m_mask;
        m_cs = m_kcs & 16'hFFFC;
        m_ss = m_kss & 16'hFFFC;
        m_redir = 1;
      end else if (sysret_req && cur_cs[1:0] == 2'd0) begin
        tag = "R6";
        m_ip = m_link_ip;
        m_flags = m_link_flags;
        m_cs = m_ucs | 16'h0003;
        m_ss = m_uss | 16'h0003;
        m_redir = 1;
      end else if (sysret_req) begin
        tag = "R7";
        m_fault = 1;
      end else begin
        tag = cfg_we ? "R9" : "R10";
      end
      if (cfg_we) begin
        case (cfg_sel)
          3'd0: m_target = cfg_wdata;
          3'd1: m_mask = cfg_wdata[FL_W-1:0];
          3'd2: m_kcs = cfg_wdata[15:0];
          3'd3: m_kss = cfg_wdata[15:0];
          3'd4: m_ucs = cfg_wdata[15:0];
          3'd5: m_uss = cfg_wdata[15:0];
          default: ;
        endcase
      end
    end
  end

  int n_cmp = 0, n_bad = 0;

  task automatic cmp(string what, string rq, logic [IP_W-1:0] act, logic [IP_W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic compare_all();
    string t_link, t_sel, t_pulse;
    t_link  = (tag == "R3") ? "R2" : tag;
    t_sel   = (tag == "R3") ? "R4" : tag;
    t_pulse = (tag == "R3") ? "R5" : tag;
    cmp("nxt_ip", tag, nxt_ip, m_ip);
    cmp("nxt_flags", tag, IP_W'(nxt_flags), IP_W'(m_flags));
    cmp("nxt_cs", t_sel, IP_W'(nxt_cs), IP_W'(m_cs));
    cmp("nxt_ss", t_sel, IP_W'(nxt_ss), IP_W'(m_ss));
    cmp("link_ip", t_link, link_ip, m_link_ip);
    cmp("link_flags", t_link, IP_W'(link_flags), IP_W'(m_link_flags));
    cmp("redirect", t_pulse, IP_W'(redirect), IP_W'(m_redir));
    cmp("gp_fault", tag, IP_W'(gp_fault), IP_W'(m_fault));
  endtask

  task automatic step(bit sc, bit sr, logic [IP_W-1:0] ip, logic [FL_W-1:0] fl,
                      logic [15:0] cs, bit we, logic [2:0] sel, logic [IP_W-1:0] wd);
    syscall_req = sc; sysret_req = sr; cur_ip = ip; cur_flags = fl; cur_cs = cs;
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    @(negedge clk);
    compare_all();
  endtask

  task automatic cfg(logic [2:0] sel, logic [IP_W-1:0] wd);
    step(0, 0, '0, '0, 16'h0010, 1, sel, wd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    compare_all();                       // R1 reset values
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();
    // R9: program configuration, including unused codes 6 and 7
    cfg(3'd0, 64'hFFFF_8000_0010_0000);
    cfg(3'd1, 64'h0000_0000_0004_0700);
    cfg(3'd2, 64'h0000_0000_0000_0013); // ring bits must be forced to 0 (R4)
    cfg(3'd3, 64'h0000_0000_0000_0018);
    cfg(3'd4, 64'h0000_0000_0000_0030); // ring bits forced to 3 (R6)
    cfg(3'd5, 64'h0000_0000_0000_002B);
    cfg(3'd6, 64'hDEAD_BEEF_DEAD_BEEF);
    cfg(3'd7, 64'hDEAD_BEEF_DEAD_BEEF);
    // R2 R3 R4 R5: entry from user ring
    step(1, 0, 64'h0000_7FFF_1234_5678, 32'h0004_0246, 16'h0033, 0, 0, 0);
    step(0, 0, 64'h1, 32'h1, 16'h0010, 0, 0, 0); // R10 hold
    // R6: legal return from ring 0
    step(0, 1, 64'h9, 32'h9, 16'h0010, 0, 0, 0);
    // R7: illegal return from ring 3 and ring 1
    step(0, 1, 64'h9, 32'h9, 16'h0033, 0, 0, 0);
    step(0, 1, 64'h9, 32'h9, 16'h0011, 0, 0, 0);
    // R8: both strobes at ring 3
    step(1, 1, 64'hAAAA_0000_0000_0001, 32'hFFFF_FFFF, 16'h0033, 0, 0, 0);
    // R9: write target in same cycle as entry uses the old target
    step(1, 0, 64'hBBBB, 32'h0000_0700, 16'h0033, 1, 3'd0, 64'h1111_2222_3333_4444);
    step(1, 0, 64'hCCCC, 32'h0000_0200, 16'h0033, 0, 0, 0);
    step(0, 1, 64'h0, 32'h0, 16'h0000, 0, 0, 0);
    // Random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      step(r < 20 || r >= 95, (r >= 20 && r < 40) || r >= 95,
           {$urandom, $urandom}, $urandom, 16'($urandom),
           ($urandom_range(0, 9) == 0), 3'($urandom), {$urandom, $urandom});
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule